// File: doc/BRIEF.md
# Serial 1-0-1 Pattern Detector with Selectable Overlap

This block watches a serial bit stream, taking one bit per clock, and raises a one-cycle detect flag in the same cycle that the last bit of the pattern 1, 0, 1 arrives. The flag is a Mealy output. It is decoded from the current state and the present input bit, so no extra register lies between the arriving bit and the flag.

A run-time select input chooses between two kinds of matching. With overlap on, the closing 1 of a match may also open the next match. With overlap off, each bit belongs to at most one match, and the machine restarts from idle after every detection. The select is sampled every cycle. It is expected to stay fixed while a match is partly built.

The machine has three states in a two-bit code: idle (00), one seen (01), and one-then-zero seen (10). The reset is synchronous and active low.

Top module: `trio_match_fsm`

## Requirements
- R1: `hit` is combinational and rises in the same cycle as the bit that completes 1, 0, 1. It is valid before the clock edge that consumes that bit.
- R2: `hit` is high only when the three most recent bits taken since reset are 1, 0, 1, with the oldest first. Fewer than three bits since reset never give a hit.
- R3: With `overlap_en`=1, the closing 1 of a match counts as the first 1 of the next match. The stream 1,0,1,0,1 therefore gives hits on its third and fifth bits.
- R4: With `overlap_en`=0, the closing 1 of a match never starts a new match. The stream 1,0,1,0,1 gives a hit only on its third bit, and the machine returns to idle after each hit.
- R5: With `overlap_en`=0, the input 0110101011001 (first bit first) gives the output 0000100010000.
- R6: With `overlap_en`=1, the input 0110101011001 gives the output 0000101010000.
- R7: While `rst_n` is low, `hit` is 0. A clock edge with `rst_n` low returns the machine to idle (code 00) and discards any partial match.
- R8: A run of 1s keeps the machine in the one-seen state (so 1,1,0,1 hits on the fourth bit). Two 0s in a row abandon the partial match (so 1,0,0,1 gives no hit). The unused code 11 is never entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit, one per cycle |
| overlap_en | input | 1 | 1 selects overlapping matches, 0 selects non-overlapping |
| hit | output | 1 | Combinational detect flag for the current bit |

## Verification
The bench goes after the bit that follows a match.

- **Closing 1 handled in the wrong mode.** Here the streams 10101 and 1010101 are the telling cases. A design that picks the wrong post-match state in one mode would either miss every second hit or report hits that reuse a consumed bit.
- **Partial match not cleared by reset.** A reset between "10" and "1" catches a design that holds the partial match through reset. Such a design would fire on the first bit after reset.
- **Wrong handling of repeated bits.** Runs of repeated 1s and repeated 0s separate a design that drops back to idle on a second 1, which would miss 1101, from one that keeps the one-then-zero state on a second 0, which would falsely hit on 1001.
- **Random streams.** Long random streams in both modes are compared bit for bit against a model built on the history of bits and past hits.

// File: rtl/trio_pkg.sv
// Package: shared state type and widths for the 1-0-1 detector.
// Assumes a two-bit state code with one unused value (11).
package trio_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 2'b00,
        ST_ONE     = 2'b01,
        ST_ONEZERO = 2'b10
    } trio_state_t;
endpackage

// File: rtl/trio_next_state.sv
// Next-state logic for the 1-0-1 detector.
// Assumes overlap_en is steady while a match is partly built.
// Any state outside the three legal codes goes back to idle.
module trio_next_state
    import trio_pkg::*;
(
    input  trio_state_t cur_state,
    input  logic        bit_in,
    input  logic        overlap_en,
    output trio_state_t nxt_state
);
    // Purpose: pick the state that follows the current state and bit.
    always_comb begin
        case (cur_state)
            ST_IDLE:    nxt_state = bit_in ? ST_ONE : ST_IDLE;
            ST_ONE:     nxt_state = bit_in ? ST_ONE : ST_ONEZERO;
            ST_ONEZERO: begin
                if (bit_in && overlap_en) begin
                    nxt_state = ST_ONE;
                end else begin
                    nxt_state = ST_IDLE;
                end
            end
            default:    nxt_state = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/trio_hit_decode.sv
// Mealy output decode: flags a completed 1-0-1 from the state and the present bit.
// Assumes rst_n is active low. The flag is held low during reset and in the unused code.
module trio_hit_decode
    import trio_pkg::*;
(
    input  trio_state_t cur_state,
    input  logic        bit_in,
    input  logic        rst_n,
    output logic        hit
);
    // Purpose: raise hit when a 1 arrives after the 1-0 prefix.
    always_comb begin
        hit = 1'b0;
        if (rst_n && (cur_state == ST_ONEZERO) && bit_in) begin
            hit = 1'b1;
        end
    end
endmodule

// File: rtl/trio_state_reg.sv
// State register with synchronous active-low reset to idle.
// Assumes a single clock domain.
module trio_state_reg
    import trio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  trio_state_t d_state,
    output trio_state_t q_state
);
    // Purpose: hold the present state and clear it to idle on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_state <= ST_IDLE;
        end else begin
            q_state <= d_state;
        end
    end
endmodule

// File: rtl/trio_match_fsm.sv
// Top: serial 1-0-1 Mealy detector with run-time overlap select.
// Assumes overlap_en changes only while no partial match is held.
module trio_match_fsm
    import trio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic overlap_en,
    output logic hit
);
    trio_state_t state_q;
    trio_state_t state_d;

    trio_next_state u_next (
        .cur_state  (state_q),
        .bit_in     (bit_in),
        .overlap_en (overlap_en),
        .nxt_state  (state_d)
    );

    trio_state_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_state (state_d),
        .q_state (state_q)
    );

    trio_hit_decode u_hit (
        .cur_state (state_q),
        .bit_in    (bit_in),
        .rst_n     (rst_n),
        .hit       (hit)
    );
endmodule

// File: rtl/trio_match_checker.sv
// Checker: temporal properties of the 1-0-1 detector, bound to the top.
// Assumes the bench holds rst_n low from time zero.
module trio_match_checker
    import trio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bit_in,
    input logic        overlap_en,
    input logic        hit,
    input trio_state_t state_q
);
    AST_HIT_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> bit_in); // R1

    AST_HIT_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !$past(bit_in)); // R2

    AST_OVERLAP_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && overlap_en) |=> (state_q == ST_ONE)); // R3

    AST_NONOVERLAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !overlap_en) |=> (state_q == ST_IDLE)); // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !hit); // R7

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE)); // R7

    AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'b11); // R8
endmodule

bind trio_match_fsm trio_match_checker i_trio_match_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (bit_in),
    .overlap_en (overlap_en),
    .hit        (hit),
    .state_q    (state_q)
);

// File: tb/test_trio_match_fsm.sv
// Bench for trio_match_fsm: directed corner cases plus seeded random streams,
// checked against a history-based reference model.
module test_trio_match_fsm;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic overlap_en = 1'b0;
    logic hit;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    // Reference model state
    logic [2:0] win = 3'b000;
    int         seen = 0;
    logic       hit_m1 = 1'b0;
    logic       hit_m2 = 1'b0;

    trio_match_fsm i_trio_match_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .overlap_en (overlap_en),
        .hit        (hit)
    );

    always #5 clk = ~clk;

    // Compute the expected flag from bit history and earlier expected hits.
    function automatic logic exp_hit(input logic [2:0] w, input int cnt,
                                     input logic ovl, input logic prior2);
        return (cnt >= 3) && (w == 3'b101) && (ovl || !prior2);
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: hit=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        win = 3'b000;
        seen = 0;
        hit_m1 = 1'b0;
        hit_m2 = 1'b0;
    endtask

    // Drive one bit, check hit before the consuming edge, update the model.
    task automatic step(input logic b, input string req);
        logic [2:0] w;
        logic e;
        @(negedge clk);
        bit_in = b;
        #2;
        w = {win[1:0], b};
        e = exp_hit(w, seen + 1, overlap_en, hit_m2);
        check(hit, e, req);
        win = w;
        seen++;
        hit_m2 = hit_m1;
        hit_m1 = e;
    endtask

    // Apply reset for one edge, checking hit stays low even on the match bit.
    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        bit_in = 1'b1;
        #2;
        check(hit, 1'b0, "R7");
        @(negedge clk);
        rst_n = 1'b1;
        overlap_en = mode;
        bit_in = 1'b0;
        model_clear();
    endtask

    task automatic run_vec(input logic [12:0] v, input logic [12:0] exp_out,
                           input string req);
        for (int i = 12; i >= 0; i--) begin
            logic [2:0] w;
            logic e;
            @(negedge clk);
            bit_in = v[i];
            #2;
            w = {win[1:0], v[i]};
            e = exp_hit(w, seen + 1, overlap_en, hit_m2);
            check(hit, exp_out[i], req);
            if (e !== exp_out[i]) begin
                n_fails++;
                $display("FAIL %s: model=%0b expected=%0b", req, e, exp_out[i]);
            end
            win = w;
            seen++;
            hit_m2 = hit_m1;
            hit_m1 = exp_out[i];
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1729));
        // R7: reset state, then hit must stay low while reset is held
        repeat (2) @(negedge clk);
        #2;
        check(hit, 1'b0, "R7");
        do_reset(1'b0);

        // R5: reference vector, non-overlapping
        run_vec(13'b0110101011001, 13'b0000100010000, "R5");
        do_reset(1'b1);
        // R6: reference vector, overlapping
        run_vec(13'b0110101011001, 13'b0000101010000, "R6");

        // R3: 1,0,1,0,1 overlapping gives hits on bits 3 and 5
        do_reset(1'b1);
        step(1, "R3"); step(0, "R3"); step(1, "R3"); step(0, "R3"); step(1, "R3");
        // R4: same stream without overlap gives one hit
        do_reset(1'b0);
        step(1, "R4"); step(0, "R4"); step(1, "R4"); step(0, "R4"); step(1, "R4");

        // R2: fewer than three bits since reset never hit
        do_reset(1'b1);
        step(1, "R2"); step(0, "R2");
        // R7: reset discards the partial 1,0
        do_reset(1'b1);
        step(1, "R7");

        // R8: runs of 1s keep the prefix, double 0 abandons it
        do_reset(1'b0);
        step(1, "R8"); step(1, "R8"); step(1, "R8"); step(0, "R8"); step(1, "R8");
        step(1, "R8"); step(0, "R8"); step(0, "R8"); step(1, "R8");

        // R1: hit valid before the edge, checked on random streams in both modes
        for (int seg = 0; seg < 40; seg++) begin
            do_reset(1'($urandom_range(0, 1)));
            for (int k = 0; k < 200; k++) begin
                step(1'($urandom_range(0, 1)), "R1");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule